// File: doc/BRIEF.md
# Sampled Interrupt Poll and Vector Unit

This unit decides when a small 8-bit processor core takes an interrupt. Every machine cycle it captures the raw request flags from the peripherals at one fixed phase point. In the next machine cycle, at the same phase point, it evaluates what it captured. The evaluation filters the requests through a global enable, a per-source enable and a per-source priority bit. It also consults the sequencer's status strobes. When a request survives every check, the unit sends the sequencer a one-clock call pulse with the vector address of the chosen source.

There are two priority levels, and each has an in-service bit. The unit sets the bit for a level when it issues a call at that level, and a return-from-interrupt clears it. A request that loses at evaluation time is not kept. The next evaluation sees only what was captured in the cycle before it.

The sequencer supplies the machine-cycle phase as a count from 0 to 11, so a cycle has six states of two phases each. The capture point is state 5, phase 2, which is phase count 9 (`SAMPLE_PH`).

Top module: `irq_poll_top`

## Requirements
- R1: Request flags are captured only on a clock edge where `mc_phase` equals `SAMPLE_PH` (9). A flag that is high only at other phases never produces a call.
- R2: Each evaluation takes place on the `SAMPLE_PH` edge and uses the flags captured on the previous `SAMPLE_PH` edge. A flag held high through machine cycle k gives its call pulse one clock after the `SAMPLE_PH` edge of machine cycle k+1. Evaluation repeats in every machine cycle.
- R3: No call is issued unless `last_cycle` is high at the evaluation edge.
- R4: No call is issued when `reti_now` or `cfg_write` is high at the evaluation edge.
- R5: No call is issued while the high level is in service. While only the low level is in service, only a high-priority request can be called.
- R6: The unit does not remember a blocked request. If the flag is low at the next capture, no call follows.
- R7: Eligible high-priority requests (`src_prio` bit = 1) win over low-priority ones. Within a level, the lowest source index wins.
- R8: `call_req` is a single-clock pulse. `call_vec` equals `VEC_BASE` + 8 × source index, and `call_src` and `call_hi` identify the source and its level.
- R9: A source is eligible only if `glob_en` is high and its `src_en` bit is high. Disabled flags are still captured, so a source that is enabled later sees the value captured before the enable.
- R10: `in_service[1]` (high level) or `in_service[0]` (low level) is set by a call at that level. When `reti_now` is high at an evaluation edge, it clears the high bit if that bit is set, and otherwise the low bit.
- R11: After reset, `call_req`, `in_service` and the captured flags are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mc_phase | input | 4 | Machine-cycle phase count, 0 to 11 |
| irq_flags | input | N_SRC | Raw request flags |
| src_en | input | N_SRC | Per-source enable |
| glob_en | input | 1 | Global enable |
| src_prio | input | N_SRC | Per-source priority, 1 = high |
| last_cycle | input | 1 | Current cycle is the last of the instruction |
| reti_now | input | 1 | A return-from-interrupt is executing |
| cfg_write | input | 1 | Enable or priority registers are being written |
| call_req | output | 1 | One-clock hardware call request |
| call_vec | output | VEC_W | Vector address of the called source |
| call_src | output | IDX_W | Index of the called source |
| call_hi | output | 1 | Level of the called source |
| in_service | output | 2 | In-service bits: [1] high level, [0] low level |

## Verification
Two things can fall on the same evaluation edge: a return-from-interrupt that clears an in-service bit, and a pending request that would be called at that level. The bench provokes this by holding a request pending while `reti_now` is high on the evaluation edge. The expected result is that the bit clears and no call is issued. The call should then follow at the next instruction end, or never if the flag has been dropped by then. The random phase drives `reti_now`, `cfg_write` and `last_cycle` together at random, so these collisions occur many times, and a bench model judges each one.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int SRC_MAX = 32;

  // Index of the lowest set bit, 0 if none.
  function automatic int lowest_set(input logic [SRC_MAX-1:0] m);
    int r;
    r = 0;
    for (int i = SRC_MAX - 1; i >= 0; i--)
      if (m[i]) r = i;
    return r;
  endfunction

  // Vector address: base plus index times eight.
  function automatic logic [15:0] vec_of(input logic [15:0] base, input int idx);
    return base + 16'(idx * 8);
  endfunction
endpackage

// File: rtl/irq_sampler.sv
module irq_sampler #(
  parameter int N_SRC = 8,
  parameter int SAMPLE_PH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       mc_phase,
  input  logic [N_SRC-1:0] irq_flags,
  output logic             sample_tick,
  output logic [N_SRC-1:0] smp
);
  assign sample_tick = (mc_phase == 4'(SAMPLE_PH));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) smp <= '0;
    else if (sample_tick) smp <= irq_flags;

  AST_SMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sample_tick) |-> $stable(smp)); // R1
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] smp,
  input  logic [N_SRC-1:0] src_en,
  input  logic             glob_en,
  input  logic [N_SRC-1:0] src_prio,
  output logic             cand_valid,
  output logic             cand_hi,
  output logic [IDX_W-1:0] cand_idx
);
  import irq_pkg::*;
  logic [N_SRC-1:0] eligible, hi_mask, lo_mask, pick_mask;

  assign eligible  = smp & src_en & {N_SRC{glob_en}};
  assign hi_mask   = eligible & src_prio;
  assign lo_mask   = eligible & ~src_prio;
  assign cand_valid = |eligible;
  assign cand_hi   = |hi_mask;
  assign pick_mask = cand_hi ? hi_mask : lo_mask;
  assign cand_idx  = IDX_W'(lowest_set(SRC_MAX'(pick_mask)));

  AST_PICK_ELIG: assert final (!cand_valid || pick_mask[cand_idx]); // R7
endmodule

// File: rtl/irq_service.sv
module irq_service (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       poll_tick,
  input  logic       fire,
  input  logic       fire_hi,
  input  logic       reti_now,
  output logic [1:0] in_service
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) in_service <= 2'b00;
    else if (poll_tick) begin
      if (reti_now) begin
        if (in_service[1]) in_service[1] <= 1'b0;
        else in_service[0] <= 1'b0;
      end else if (fire) begin
        if (fire_hi) in_service[1] <= 1'b1;
        else in_service[0] <= 1'b1;
      end
    end

  AST_SVC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_service[1]) |-> $past(fire && fire_hi)); // R10
  AST_SVC_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_service[0]) |-> $past(reti_now && poll_tick)); // R10
endmodule

// File: rtl/irq_poll_top.sv
module irq_poll_top #(
  parameter int N_SRC = 8,
  parameter int SAMPLE_PH = 9,
  parameter logic [15:0] VEC_BASE = 16'h0003,
  localparam int VEC_W = 16,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       mc_phase,
  input  logic [N_SRC-1:0] irq_flags,
  input  logic [N_SRC-1:0] src_en,
  input  logic             glob_en,
  input  logic [N_SRC-1:0] src_prio,
  input  logic             last_cycle,
  input  logic             reti_now,
  input  logic             cfg_write,
  output logic             call_req,
  output logic [VEC_W-1:0] call_vec,
  output logic [IDX_W-1:0] call_src,
  output logic             call_hi,
  output logic [1:0]       in_service
);
  import irq_pkg::*;

  logic             poll_tick;
  logic [N_SRC-1:0] smp;
  logic             cand_valid, cand_hi;
  logic [IDX_W-1:0] cand_idx;
  logic             svc_block, seq_block, fire;

  irq_sampler #(.N_SRC(N_SRC), .SAMPLE_PH(SAMPLE_PH)) u_smp (
    .clk(clk), .rst_n(rst_n), .mc_phase(mc_phase), .irq_flags(irq_flags),
    .sample_tick(poll_tick), .smp(smp));

  irq_arbiter #(.N_SRC(N_SRC)) u_arb (
    .smp(smp), .src_en(src_en), .glob_en(glob_en), .src_prio(src_prio),
    .cand_valid(cand_valid), .cand_hi(cand_hi), .cand_idx(cand_idx));

  assign svc_block = in_service[1] | (in_service[0] & ~cand_hi);
  assign seq_block = ~last_cycle | reti_now | cfg_write;
  assign fire      = poll_tick & cand_valid & ~svc_block & ~seq_block;

  irq_service u_svc (
    .clk(clk), .rst_n(rst_n), .poll_tick(poll_tick), .fire(fire),
    .fire_hi(cand_hi), .reti_now(reti_now), .in_service(in_service));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      call_req <= 1'b0;
      call_vec <= '0;
      call_src <= '0;
      call_hi  <= 1'b0;
    end else begin
      call_req <= fire;
      if (fire) begin
        call_vec <= vec_of(VEC_BASE, int'(cand_idx));
        call_src <= cand_idx;
        call_hi  <= cand_hi;
      end
    end

  AST_CALL_ON_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> $past(poll_tick)); // R2
  AST_CALL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> $past(last_cycle)); // R3
  AST_CALL_NO_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> !$past(reti_now) && !$past(cfg_write)); // R4
  AST_CALL_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> !$past(in_service[1])); // R5
  AST_CALL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |=> !call_req); // R8
  AST_CALL_GLOB: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> $past(glob_en)); // R9
endmodule

// File: tb/tb_irq_poll_top.sv
module tb_irq_poll_top;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  logic [3:0] mc_phase = 0;
  logic [N-1:0] irq_flags = 0, src_en = 0, src_prio = 0;
  logic glob_en = 0, last_cycle = 0, reti_now = 0, cfg_write = 0;
  logic call_req, call_hi;
  logic [15:0] call_vec;
  logic [2:0] call_src;
  logic [1:0] in_service;
  int checks = 0, errors = 0;
  logic [N-1:0] m_smp = 0;
  logic [1:0] m_isr = 0;

  always #10 clk = ~clk;

  irq_poll_top dut (.clk(clk), .rst_n(rst_n), .mc_phase(mc_phase), .irq_flags(irq_flags),
    .src_en(src_en), .glob_en(glob_en), .src_prio(src_prio), .last_cycle(last_cycle),
    .reti_now(reti_now), .cfg_write(cfg_write), .call_req(call_req), .call_vec(call_vec),
    .call_src(call_src), .call_hi(call_hi), .in_service(in_service));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected pick: returns -1 when no call.
  function automatic int exp_pick(input logic [N-1:0] s, en, pr, input logic g,
                                  input logic [1:0] isr, input logic lc, rt, wr);
    logic [N-1:0] e;
    int hi, lo;
    e = g ? (s & en) : '0;
    hi = -1; lo = -1;
    for (int i = N - 1; i >= 0; i--) begin
      if (e[i] && pr[i]) hi = i;
      if (e[i] && !pr[i]) lo = i;
    end
    if (!lc || rt || wr || isr[1]) return -1;
    if (hi >= 0) return hi;
    if (isr[0]) return -1;
    return lo;
  endfunction

  // One machine cycle: fl at the capture phase, fo at all other phases.
  task automatic mcyc(input logic [N-1:0] fl, fo, en, pr, input logic g, lc, rt, wr,
                      input string req);
    int p;
    for (int ph = 0; ph < 12; ph++) begin
      @(negedge clk);
      mc_phase = 4'(ph);
      irq_flags = (ph == 9) ? fl : fo;
      src_en = en; src_prio = pr; glob_en = g;
      last_cycle = lc; reti_now = rt; cfg_write = wr;
      if (ph == 9) begin
        p = exp_pick(m_smp, en, pr, g, m_isr, lc, rt, wr);
        if (rt) begin
          if (m_isr[1]) m_isr[1] = 0; else m_isr[0] = 0;
        end else if (p >= 0) m_isr[pr[p] ? 1 : 0] = 1;
        m_smp = fl;
        @(negedge clk);
        mc_phase = 4'd10;
        chk({req, " call_req"}, 32'(call_req), 32'(p >= 0));
        if (p >= 0) begin
          chk({req, " R8 vec"}, 32'(call_vec), 32'(16'h0003 + 16'(p * 8)));
          chk({req, " R8 src"}, 32'(call_src), 32'(p));
        end
        chk({req, " R10 isr"}, 32'(in_service), 32'(m_isr));
        @(negedge clk);
        mc_phase = 4'd11;
        chk({req, " R8 pulse"}, 32'(call_req), 0);
        break;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog timeout");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R11 call", 32'(call_req), 0);
    chk("R11 isr", 32'(in_service), 0);
    rst_n = 1;
    // R1: flag only off-phase never seen
    mcyc(0, 8'h04, 8'hFF, 0, 1, 1, 0, 0, "R1");
    mcyc(0, 0, 8'hFF, 0, 1, 1, 0, 0, "R1");
    // R2: capture then call one cycle later
    mcyc(8'h04, 8'h04, 8'hFF, 0, 1, 1, 0, 0, "R2 cap");
    mcyc(0, 0, 8'hFF, 0, 1, 1, 0, 0, "R2 call");
    mcyc(0, 0, 8'hFF, 0, 1, 1, 1, 0, "R10 reti");
    // R3, R6: blocked by non-last cycle, then dropped
    mcyc(8'h02, 8'h02, 8'hFF, 0, 1, 1, 0, 0, "R3 cap");
    mcyc(0, 0, 8'hFF, 0, 1, 0, 0, 0, "R3 block");
    mcyc(0, 0, 8'hFF, 0, 1, 1, 0, 0, "R6 drop");
    // R4 cfg write blocks
    mcyc(8'h01, 8'h01, 8'hFF, 0, 1, 1, 0, 0, "R4 cap");
    mcyc(8'h01, 8'h01, 8'hFF, 0, 1, 1, 0, 1, "R4 wr");
    mcyc(0, 0, 8'hFF, 0, 1, 1, 0, 0, "R4 after");
    // R7 priority + R5 nesting
    mcyc(8'h31, 8'h31, 8'hFF, 8'h20, 1, 1, 0, 0, "R7 cap");
    mcyc(8'h31, 8'h31, 8'hFF, 8'h20, 1, 1, 0, 0, "R7 hi");
    mcyc(8'h31, 8'h31, 8'hFF, 8'h20, 1, 1, 0, 0, "R5 hi busy");
    mcyc(8'h31, 8'h31, 8'hFF, 8'h20, 1, 1, 1, 0, "R10 reti+pending");
    mcyc(8'h11, 8'h11, 8'hFF, 8'h00, 1, 1, 0, 0, "R7 lo");
    mcyc(8'h11, 8'h11, 8'hFF, 8'h00, 1, 1, 0, 0, "R5 lo busy");
    mcyc(0, 0, 8'hFF, 0, 1, 1, 1, 0, "R10 clr lo");
    // R9 enables; disabled still sampled
    mcyc(8'h08, 8'h08, 8'hFF, 0, 0, 1, 0, 0, "R9 cap");
    mcyc(0, 0, 8'hF7, 0, 0, 1, 0, 0, "R9 glob");
    mcyc(8'h40, 8'h40, 8'h00, 0, 1, 1, 0, 0, "R9 src");
    mcyc(0, 0, 8'h40, 0, 1, 1, 0, 0, "R9 late en");
    mcyc(0, 0, 8'hFF, 0, 1, 1, 1, 0, "R10 clr");
    mcyc(0, 0, 8'hFF, 0, 1, 1, 1, 0, "R10 clr2");
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [N-1:0] f;
      f = N'($urandom) & N'($urandom);
      mcyc(f, N'($urandom), N'($urandom) | 8'h0F, N'($urandom), ($urandom % 8) != 0,
           ($urandom % 3) != 0, ($urandom % 4) == 0, ($urandom % 6) == 0, "rand");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule